// File: doc/BRIEF.md
# DVB-T TPS Frame Extractor

This block sits behind the TPS carrier demodulation of a DVB-T receiver. Every OFDM symbol yields one hard signalling bit, which arrives on `tps_bit_i` with a one-cycle strobe `tps_vld_i`. The block assembles these bits into 68-bit signalling frames. It finds the frame boundary by searching for the 16-bit synchronisation word, whose polarity flips from one frame to the next. It confirms lock over two frames and then follows the frame position bit by bit. At the end of each locked frame that carried a good sync word, it copies the decoded transmission parameters into host-readable registers in one step, so the fields always belong to a single frame.

The cell identifier is 16 bits wide but is sent one byte per frame. Frames with an even index carry the upper byte and frames with an odd index carry the lower byte. The block joins the two bytes and flags the identifier valid only once it holds one of each since lock was gained. Bit correction of the frame and recovery of the TPS carriers belong to the stages ahead of this block.

A sync controller runs the locking. It has three states:
- `ST_HUNT`: sliding search on every bit.
- `ST_CONFIRM`: one candidate frame has been seen and the next sync word is awaited.
- `ST_LOCK`: tracking.

Its transitions are:
- HUNT→CONFIRM when either sync word is matched.
- CONFIRM→LOCK when the opposite-polarity word arrives at the expected position.
- CONFIRM→CONFIRM (restart) when the same-polarity word arrives there.
- CONFIRM→HUNT when no word is found there.
- LOCK→LOCK on a match, or on a mismatch below the miss limit.
- LOCK→HUNT on the second consecutive mismatch.

Top module: `tps_frame_extractor`

## Requirements
- R1: After reset `locked_o` is 0, all parameter outputs and `cell_id_o` are 0, and `cell_id_vld_o` is 0.
- R2: A bit is consumed only on a cycle with `tps_vld_i` high. Idle cycles of any length between bits, whatever `tps_bit_i` does during them, leave the results unchanged.
- R3: Frame bit 0 is sent first. Bits 1..16 hold the sync word, most significant bit first. The word is 16'h35EE in frames of even index and 16'hCA11 in frames of odd index.
- R4: `locked_o` rises on the cycle after the last sync bit (bit 16) of the second of two consecutive frames whose sync words are both correct and of opposite polarity.
- R5: Two consecutive frames with the same sync polarity do not produce lock. The second of them becomes the new candidate, so a following opposite-polarity frame locks.
- R6: While locked, one sync mismatch keeps lock. A second consecutive mismatch drops `locked_o` on the cycle after bit 16 of that frame. The expected polarity keeps alternating through mismatched frames.
- R7: Fields are sent most significant bit first at these positions:
  - constellation: bits 25-26
  - hierarchy: bits 27-29
  - HP code rate: bits 30-32
  - LP code rate: bits 33-35
  - guard: bits 36-37
  - mode: bits 38-39

  All parameter outputs change together on the cycle after bit 67 of a locked frame with a correct sync word, and at no other time.
- R8: A frame whose sync word mismatched leaves every parameter output unchanged, and losing lock does not clear them.
- R9: `frame_idx_o` reports the superframe frame index carried in bits 23-24.
- R10: The cell-identifier byte sits in bits 40-47. A frame with an even index loads `cell_id_o[15:8]` and a frame with an odd index loads `cell_id_o[7:0]`. `cell_id_vld_o` goes high once both halves have been loaded since lock. Both halves are discarded when lock is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tps_vld_i | input | 1 | Strobe: `tps_bit_i` holds a new TPS bit |
| tps_bit_i | input | 1 | Hard TPS bit of the current symbol |
| locked_o | output | 1 | Frame synchronisation achieved |
| frame_idx_o | output | 2 | Frame index within the superframe |
| mode_o | output | 2 | Transmission mode code |
| guard_o | output | 2 | Guard interval code |
| constel_o | output | 2 | Constellation code |
| hier_o | output | 3 | Hierarchy code |
| hp_rate_o | output | 3 | High-priority code rate code |
| lp_rate_o | output | 3 | Low-priority code rate code |
| cell_id_o | output | 16 | Assembled cell identifier |
| cell_id_vld_o | output | 1 | Both cell identifier bytes present |

## Verification
The hardest situations to reach from the ports are those that depend on the history of sync polarity. These are a repeated same-polarity frame restarting confirmation, and a single mismatch inside lock after which the expected polarity must still have advanced. The stimulus builds whole frames from field values and walks a table of frames with chosen sync words: correct, then deliberately wrong once, then wrong twice. Directed runs after a fresh reset feed two equal-polarity frames and then send the third frame bit by bit. They sample lock just before and just after bit 16, and the parameters just before and just after bit 67. Idle gaps with a toggling data line are inserted between bits.

// File: rtl/tps_pkg.sv
package tps_pkg;

    localparam int FRAME_LEN = 68;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int SYNC_W    = 16;
    localparam int SYNC_LAST = 16;
    localparam logic [SYNC_W-1:0] SYNC_EVEN = 16'h35EE;
    localparam logic [SYNC_W-1:0] SYNC_ODD  = 16'hCA11;

    // field positions (frame bit index of the MSB) and widths
    localparam int FNUM_POS  = 23;  localparam int FNUM_W  = 2;
    localparam int CONST_POS = 25;  localparam int CONST_W = 2;
    localparam int HIER_POS  = 27;  localparam int HIER_W  = 3;
    localparam int HP_POS    = 30;  localparam int RATE_W  = 3;
    localparam int LP_POS    = 33;
    localparam int GUARD_POS = 36;  localparam int GUARD_W = 2;
    localparam int MODE_POS  = 38;  localparam int MODE_W  = 2;
    localparam int CELL_POS  = 40;  localparam int CELL_W  = 8;

    // capture window: frame bits FNUM_POS .. WIN_LAST
    localparam int WIN_LAST  = CELL_POS + CELL_W - 1;
    localparam int WIN_W     = WIN_LAST - FNUM_POS + 1;
    localparam int HIST_W    = WIN_W - 1;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCK    = 2'd2
    } sync_state_e;

    typedef struct packed {
        logic [FNUM_W-1:0]  fnum;
        logic [CONST_W-1:0] constel;
        logic [HIER_W-1:0]  hier;
        logic [RATE_W-1:0]  hp_rate;
        logic [RATE_W-1:0]  lp_rate;
        logic [GUARD_W-1:0] guard;
        logic [MODE_W-1:0]  mode;
    } tps_params_t;

endpackage

// File: rtl/tps_bit_shifter.sv
module tps_bit_shifter #(
    parameter int DEPTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    output logic [DEPTH-1:0] hist_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_o <= '0;
        end else if (bit_vld_i) begin
            hist_o <= {hist_o[DEPTH-2:0], bit_i};
        end
    end

endmodule

// File: rtl/tps_sync_fsm.sv
module tps_sync_fsm
    import tps_pkg::*;
#(
    parameter int MISS_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic [SYNC_W-2:0] hist_i,
    output logic              locked_o,
    output logic              cap_o,
    output logic              frame_done_o,
    output logic              lock_lost_o
);

    localparam int MISS_W = $clog2(MISS_LIMIT + 1);

    sync_state_e        state_q, state_n;
    logic [POS_W-1:0]   pos_q, pos_n, pos_adv;
    logic               pol_q, pol_n;      // 1: last sync slot held the odd word
    logic               ok_q, ok_n;        // current frame's sync was good
    logic [MISS_W-1:0]  miss_q, miss_n;

    logic [SYNC_W-1:0]  win;
    logic               hit_even, hit_odd, hit_exp, at_sync, at_end;

    assign win      = {hist_i, bit_i};
    assign hit_even = (win == SYNC_EVEN);
    assign hit_odd  = (win == SYNC_ODD);
    assign hit_exp  = pol_q ? hit_even : hit_odd;
    assign at_sync  = (pos_q == POS_W'(SYNC_LAST));
    assign at_end   = (pos_q == POS_W'(FRAME_LEN - 1));
    assign pos_adv  = at_end ? '0 : pos_q + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            pol_q   <= 1'b0;
            ok_q    <= 1'b0;
            miss_q  <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            pol_q   <= pol_n;
            ok_q    <= ok_n;
            miss_q  <= miss_n;
        end
    end

    // next state
    always_comb begin
        state_n = state_q;
        pos_n   = pos_q;
        pol_n   = pol_q;
        ok_n    = ok_q;
        miss_n  = miss_q;
        if (bit_vld_i) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (hit_even || hit_odd) begin
                        state_n = ST_CONFIRM;
                        pos_n   = POS_W'(SYNC_LAST + 1);
                        pol_n   = hit_odd;
                    end
                end
                ST_CONFIRM: begin
                    pos_n = pos_adv;
                    if (at_sync) begin
                        if (hit_exp) begin
                            state_n = ST_LOCK;
                            pol_n   = ~pol_q;
                            ok_n    = 1'b1;
                            miss_n  = '0;
                        end else if (hit_even || hit_odd) begin
                            pol_n   = hit_odd;
                        end else begin
                            state_n = ST_HUNT;
                        end
                    end
                end
                ST_LOCK: begin
                    pos_n = pos_adv;
                    if (at_sync) begin
                        pol_n = ~pol_q;
                        if (hit_exp) begin
                            ok_n   = 1'b1;
                            miss_n = '0;
                        end else begin
                            ok_n = 1'b0;
                            if (miss_q == MISS_W'(MISS_LIMIT - 1)) begin
                                state_n = ST_HUNT;
                                miss_n  = '0;
                            end else begin
                                miss_n = miss_q + 1'b1;
                            end
                        end
                    end
                end
                default: state_n = ST_HUNT;
            endcase
        end
    end

    // outputs
    always_comb begin
        locked_o     = (state_q == ST_LOCK);
        cap_o        = bit_vld_i && (state_q != ST_HUNT) &&
                       (pos_q == POS_W'(WIN_LAST));
        frame_done_o = bit_vld_i && (state_q == ST_LOCK) && at_end && ok_q;
        lock_lost_o  = (state_q == ST_LOCK) && (state_n == ST_HUNT);
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> $stable(pos_q) && $stable(state_q));

    // R4
    lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(state_q) == ST_CONFIRM) && $past(bit_vld_i));

    // R6
    drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked_o) |-> ($past(miss_q) == MISS_W'(MISS_LIMIT - 1)));

    // R7
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_W'(FRAME_LEN - 1));

endmodule

// File: rtl/tps_field_regs.sv
module tps_field_regs
    import tps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              frame_done_i,
    input  logic              lock_lost_i,
    input  logic [HIST_W-1:0] hist_i,
    input  logic              bit_i,
    output tps_params_t       params_o,
    output logic [15:0]       cell_id_o,
    output logic              cell_vld_o
);

    // stage[WIN_LAST - k] holds frame bit k
    logic [WIN_W-1:0] stage_q;
    logic             hi_seen_q, lo_seen_q;
    tps_params_t      dec;
    logic [CELL_W-1:0] cell_byte;

    always_comb begin
        dec.fnum    = stage_q[WIN_LAST - FNUM_POS  -: FNUM_W];
        dec.constel = stage_q[WIN_LAST - CONST_POS -: CONST_W];
        dec.hier    = stage_q[WIN_LAST - HIER_POS  -: HIER_W];
        dec.hp_rate = stage_q[WIN_LAST - HP_POS    -: RATE_W];
        dec.lp_rate = stage_q[WIN_LAST - LP_POS    -: RATE_W];
        dec.guard   = stage_q[WIN_LAST - GUARD_POS -: GUARD_W];
        dec.mode    = stage_q[WIN_LAST - MODE_POS  -: MODE_W];
        cell_byte   = stage_q[WIN_LAST - CELL_POS  -: CELL_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= '0;
            params_o  <= '0;
            cell_id_o <= '0;
            hi_seen_q <= 1'b0;
            lo_seen_q <= 1'b0;
        end else begin
            if (cap_i) begin
                stage_q <= {hist_i, bit_i};
            end
            if (lock_lost_i) begin
                hi_seen_q <= 1'b0;
                lo_seen_q <= 1'b0;
                cell_id_o <= '0;
            end else if (frame_done_i) begin
                params_o <= dec;
                if (!dec.fnum[0]) begin
                    cell_id_o[15:8] <= cell_byte;
                    hi_seen_q       <= 1'b1;
                end else begin
                    cell_id_o[7:0]  <= cell_byte;
                    lo_seen_q       <= 1'b1;
                end
            end
        end
    end

    assign cell_vld_o = hi_seen_q && lo_seen_q;

    // R8
    param_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done_i |=> $stable(params_o));

    // R10
    cid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cell_vld_o) |-> $past(frame_done_i));

    // R10
    cid_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_lost_i |=> !cell_vld_o);

endmodule

// File: rtl/tps_frame_extractor.sv
module tps_frame_extractor
    import tps_pkg::*;
#(
    parameter int MISS_LIMIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tps_vld_i,
    input  logic        tps_bit_i,
    output logic        locked_o,
    output logic [1:0]  frame_idx_o,
    output logic [1:0]  mode_o,
    output logic [1:0]  guard_o,
    output logic [1:0]  constel_o,
    output logic [2:0]  hier_o,
    output logic [2:0]  hp_rate_o,
    output logic [2:0]  lp_rate_o,
    output logic [15:0] cell_id_o,
    output logic        cell_id_vld_o
);

    logic [HIST_W-1:0] hist;
    logic              cap, frame_done, lock_lost;
    tps_params_t       params;

    tps_bit_shifter #(.DEPTH(HIST_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_vld_i (tps_vld_i),
        .bit_i     (tps_bit_i),
        .hist_o    (hist)
    );

    tps_sync_fsm #(.MISS_LIMIT(MISS_LIMIT)) sync_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld_i    (tps_vld_i),
        .bit_i        (tps_bit_i),
        .hist_i       (hist[SYNC_W-2:0]),
        .locked_o     (locked_o),
        .cap_o        (cap),
        .frame_done_o (frame_done),
        .lock_lost_o  (lock_lost)
    );

    tps_field_regs fields_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cap_i        (cap),
        .frame_done_i (frame_done),
        .lock_lost_i  (lock_lost),
        .hist_i       (hist),
        .bit_i        (tps_bit_i),
        .params_o     (params),
        .cell_id_o    (cell_id_o),
        .cell_vld_o   (cell_id_vld_o)
    );

    assign frame_idx_o = params.fnum;
    assign mode_o      = params.mode;
    assign guard_o     = params.guard;
    assign constel_o   = params.constel;
    assign hier_o      = params.hier;
    assign hp_rate_o   = params.hp_rate;
    assign lp_rate_o   = params.lp_rate;

endmodule

// File: tb/tps_frame_extractor_tb_top.sv
`timescale 1ns/1ps
module tps_frame_extractor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        locked;
    logic [1:0]  fidx, mode, guard, constel;
    logic [2:0]  hier, hp, lp;
    logic [15:0] cid;
    logic        cid_vld;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    tps_frame_extractor dut_i (
        .clk(clk), .rst_n(rst_n), .tps_vld_i(vld), .tps_bit_i(bit_in),
        .locked_o(locked), .frame_idx_o(fidx), .mode_o(mode), .guard_o(guard),
        .constel_o(constel), .hier_o(hier), .hp_rate_o(hp), .lp_rate_o(lp),
        .cell_id_o(cid), .cell_id_vld_o(cid_vld)
    );

    typedef struct packed {
        logic [1:0] ss;   // 0: even word, 1: odd word, 2: corrupt
        logic [1:0] fn;
        logic [1:0] co;
        logic [2:0] hi;
        logic [2:0] hr;
        logic [2:0] lr;
        logic [1:0] gu;
        logic [1:0] mo;
        logic [7:0] cb;
        logic [1:0] gap;
        logic       el;   // expected lock after frame
        logic       eu;   // expected parameter update
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd1, 3'd0, 3'd2, 3'd0, 2'd1, 2'd1, 8'hA5, 2'd0, 1'b0, 1'b0},
        '{2'd1, 2'd1, 2'd2, 3'd1, 3'd3, 3'd1, 2'd2, 2'd0, 8'h3C, 2'd1, 1'b1, 1'b1},
        '{2'd0, 2'd2, 2'd0, 3'd4, 3'd4, 3'd2, 2'd3, 2'd2, 8'h7E, 2'd0, 1'b1, 1'b1},
        '{2'd2, 2'd3, 2'd1, 3'd2, 3'd1, 3'd4, 2'd0, 2'd1, 8'hFF, 2'd2, 1'b1, 1'b0},
        '{2'd0, 2'd0, 2'd1, 3'd3, 3'd0, 3'd3, 2'd0, 2'd1, 8'h11, 2'd0, 1'b1, 1'b1},
        '{2'd1, 2'd1, 2'd2, 3'd5, 3'd2, 3'd0, 2'd1, 2'd0, 8'h22, 2'd1, 1'b1, 1'b1},
        '{2'd2, 2'd2, 2'd3, 3'd6, 3'd1, 3'd1, 2'd2, 2'd3, 8'h99, 2'd0, 1'b1, 1'b0},
        '{2'd2, 2'd3, 2'd0, 3'd7, 3'd3, 3'd2, 2'd3, 2'd2, 8'h44, 2'd1, 1'b0, 1'b0}
    };

    // bench model of expected outputs
    logic [1:0] e_fn, e_co, e_gu, e_mo;
    logic [2:0] e_hi, e_hr, e_lr;
    logic [7:0] e_hb, e_lb;
    logic       e_hs, e_ls;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [67:0] put(logic [67:0] f, int a, int w, logic [15:0] v);
        for (int i = 0; i < w; i++) f[a+i] = v[w-1-i];
        return f;
    endfunction

    // R3: frame bit k stored at index k, fields MSB first
    function automatic logic [67:0] mk(vec_t v);
        logic [67:0] f = '0;
        logic [15:0] sw = (v.ss == 2'd0) ? 16'h35EE : (v.ss == 2'd1) ? 16'hCA11 : 16'h0000;
        f = put(f, 1, 16, sw);
        f = put(f, 17, 6, 16'h0017);
        f = put(f, 23, 2, {14'd0, v.fn});
        f = put(f, 25, 2, {14'd0, v.co});
        f = put(f, 27, 3, {13'd0, v.hi});
        f = put(f, 30, 3, {13'd0, v.hr});
        f = put(f, 33, 3, {13'd0, v.lr});
        f = put(f, 36, 2, {14'd0, v.gu});
        f = put(f, 38, 2, {14'd0, v.mo});
        f = put(f, 40, 8, {8'd0, v.cb});
        return f;
    endfunction

    task automatic send_bit(logic b, int gap);
        @(negedge clk); vld = 1'b1; bit_in = b;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); vld = 1'b0; bit_in = ~b;   // R2 idle toggling
        end
    endtask

    task automatic idle();
        @(negedge clk); vld = 1'b0;
    endtask

    task automatic send_frame(vec_t v);
        logic [67:0] f = mk(v);
        for (int k = 0; k < 68; k++) send_bit(f[k], int'(v.gap));
        idle();
    endtask

    task automatic model_update(vec_t v);
        if (v.eu) begin
            e_fn = v.fn; e_co = v.co; e_hi = v.hi; e_hr = v.hr;
            e_lr = v.lr; e_gu = v.gu; e_mo = v.mo;
            if (!v.fn[0]) begin e_hb = v.cb; e_hs = 1'b1; end
            else          begin e_lb = v.cb; e_ls = 1'b1; end
        end
        if (!v.el) begin e_hs = 1'b0; e_ls = 1'b0; end
    endtask

    task automatic chk_fields();
        chk("R9 frame_idx", {30'd0, fidx}, {30'd0, e_fn});
        chk("R7 constel",   {30'd0, constel}, {30'd0, e_co});
        chk("R7 hier",      {29'd0, hier}, {29'd0, e_hi});
        chk("R7 hp_rate",   {29'd0, hp}, {29'd0, e_hr});
        chk("R7 lp_rate",   {29'd0, lp}, {29'd0, e_lr});
        chk("R7 guard",     {30'd0, guard}, {30'd0, e_gu});
        chk("R7 mode",      {30'd0, mode}, {30'd0, e_mo});
        chk("R10 cell_id_vld", {31'd0, cid_vld}, {31'd0, e_hs && e_ls});
        if (e_hs && e_ls) chk("R10 cell_id", {16'd0, cid}, {16'd0, e_hb, e_lb});
    endtask

    task automatic clear_model();
        e_fn = '0; e_co = '0; e_hi = '0; e_hr = '0; e_lr = '0; e_gu = '0; e_mo = '0;
        e_hb = '0; e_lb = '0; e_hs = 1'b0; e_ls = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; vld = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_model();
        chk("R1 locked", {31'd0, locked}, 32'd0);
        chk("R1 cell_id", {16'd0, cid}, 32'd0);
        chk_fields();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        vec_t a0, a1, b2;
        logic [67:0] f;
        do_reset();

        // table walk: R3 R4 R6 R7 R8 R9 R10, gaps for R2
        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i]);
            model_update(VECS[i]);
            chk($sformatf("R4/R6 locked after frame %0d", i), {31'd0, locked}, {31'd0, VECS[i].el});
            chk_fields();   // R8: corrupt frames leave fields unchanged
        end

        // R5: two equal-polarity frames, then opposite polarity
        do_reset();
        a0 = '{2'd0, 2'd0, 2'd3, 3'd1, 3'd1, 3'd1, 2'd1, 2'd1, 8'h55, 2'd0, 1'b0, 1'b0};
        a1 = '{2'd0, 2'd2, 2'd2, 3'd2, 3'd2, 3'd2, 2'd2, 2'd2, 8'h66, 2'd1, 1'b0, 1'b0};
        b2 = '{2'd1, 2'd1, 2'd3, 3'd6, 3'd5, 3'd3, 2'd3, 2'd3, 8'h77, 2'd0, 1'b1, 1'b1};
        send_frame(a0);
        send_frame(a1);
        chk("R5 no lock on equal polarity", {31'd0, locked}, 32'd0);
        chk("R5 fields untouched", {30'd0, constel}, 32'd0);
        f = mk(b2);
        for (int k = 0; k < 16; k++) send_bit(f[k], 0);
        idle();
        chk("R4 unlocked before bit 16", {31'd0, locked}, 32'd0);
        send_bit(f[16], 0);
        idle();
        chk("R4 locked after bit 16", {31'd0, locked}, 32'd1);
        for (int k = 17; k < 67; k++) send_bit(f[k], 0);
        idle();
        chk("R7 no update before bit 67", {30'd0, constel}, 32'd0);
        chk("R7 mode unchanged before bit 67", {30'd0, mode}, 32'd0);
        send_bit(f[67], 0);
        idle();
        model_update(b2);
        chk_fields();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule